// File: doc/BRIEF.md
# Receive Label and Source/Destination Filter

This block sits behind a serial word receiver. Each time the receiver finishes a 32-bit word it raises a one-cycle completion strobe. The filter then decides whether that word goes into a 32-entry receive queue. The decision uses two checks, and each check can be switched on or off on its own:

- **Label match.** The low eight bits of the word (word bits 1 to 8) are compared with all sixteen entries of a programmable label table.
- **Source/destination check.** Word bits 9 and 10 are compared with a two-bit expected code.

A word that fails any enabled check is discarded and leaves no trace on the flags.

The host programs and inspects the label table through an 8-bit port and two strobes. Raising the label-mode input starts a table session. In a session, write strobes fill table locations 1 to 16 in order, and read strobes present them back in the same order. Completed words that arrive during a session are discarded. Lowering the label-mode input ends the session and rewinds both session counters.

Outside a session, a read strobe removes the oldest queued word. The queue drives three flags: data-ready, half-full and full. When the queue is full, a newly accepted word replaces the newest stored word instead of being lost.

Top module: `rx_label_filter`

## Requirements
- R1: After reset, dataReady, halfFull and full are all 0 and all sixteen label entries hold 8'h00.
- R2: With labelMatchEn=1 and sdiCheckEn=0, a completed word is queued only if wordIn[7:0] (word bits 1-8) equals one of the sixteen stored labels; any other word is dropped and changes no flag.
- R3: The value 8'h00 is an ordinary label. A word with label 8'h00 is queued only while some table entry holds 8'h00, and is dropped otherwise.
- R4: With sdiCheckEn=1 and labelMatchEn=0, a word is queued only if wordIn[8] (word bit 9) equals sdiExpect[0] and wordIn[9] (word bit 10) equals sdiExpect[1].
- R5: With both checks disabled, every completed word is queued. With both enabled, a word is queued only if it passes both checks.
- R6: While labelMode=1, the first 16 hostWrite strobes store hostLabelIn into table locations 1 to 16 in order. Further write strobes in the same session change nothing.
- R7: While labelMode=1, labelOut presents table location 1, and each hostRead strobe advances it to the next location. After the 16th strobe, labelOut reads 8'h00 and the queue is not disturbed.
- R8: Whenever labelMode is 0, both session counters return to location 1, so a new session starts writing and reading at location 1.
- R9: A completed word arriving while labelMode=1 is never queued.
- R10: Queued words leave in arrival order. rdData shows the oldest word, and a hostRead strobe with labelMode=0 removes it. dataReady is 1 exactly while the queue holds at least one word.
- R11: halfFull is 1 while the queue holds 16 or more words. full is 1 while it holds 32.
- R12: When the queue is full and no word is removed in the same cycle, an accepted word replaces the newest entry (location 32). The count stays at 32 and the older 31 words are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordIn | input | 32 | Completed received word; bit 0 is word bit 1 |
| wordValid | input | 1 | One-cycle strobe: wordIn is a completed word |
| labelMatchEn | input | 1 | Enable the label table check |
| sdiCheckEn | input | 1 | Enable the bit 9/10 check |
| sdiExpect | input | 2 | Expected value of word bits 10 (bit 1) and 9 (bit 0) |
| labelMode | input | 1 | 1 = label table session |
| hostWrite | input | 1 | Label write strobe (session only) |
| hostRead | input | 1 | Queue pop, or label readback advance in a session |
| hostLabelIn | input | 8 | Label value to store |
| rdData | output | 32 | Oldest queued word |
| labelOut | output | 8 | Label at the current readback location |
| dataReady | output | 1 | Queue not empty |
| halfFull | output | 1 | Queue holds 16 or more words |
| full | output | 1 | Queue holds 32 words |

## Verification
The hardest case to reach from the ports is the overwrite of location 32. It needs the queue filled to exactly 32 words, then one more accepted word while no pop is pending. The stimulus first disables both checks so that every word is queued. It pushes 32 distinct words, then one extra word, and confirms that draining the queue returns 31 original words followed by the replacement.

The label-session rewind is the other subtle case. It is reached by opening a second session, writing a single 8'h00 and reading back, so that the result shows both the restart at location 1 and that a stored zero really matches.

// File: rtl/rx_label_filter_pkg.sv
package rx_label_filter_pkg;
  localparam int LBL_COUNT = 16;
  localparam int LBL_IDX_W = $clog2(LBL_COUNT);
  localparam int LABEL_W   = 8;

  typedef struct packed {
    logic                 push;
    logic                 overwrite;
    logic                 pop;
    logic                 labWe;
    logic [LBL_IDX_W-1:0] labWrIdx;
    logic [LBL_IDX_W-1:0] labRdIdx;
    logic                 labRdValid;
  } filt_strobe_t;
endpackage

// File: rtl/rx_label_filter_ctrl.sv
module rx_label_filter_ctrl
  import rx_label_filter_pkg::*;
#(
  parameter int FIFO_DEPTH = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wordValid,
  input  logic         labelMatchEn,
  input  logic         sdiCheckEn,
  input  logic         labelHit,
  input  logic         sdiHit,
  input  logic         labelMode,
  input  logic         hostWrite,
  input  logic         hostRead,
  output filt_strobe_t strb,
  output logic         dataReady,
  output logic         halfFull,
  output logic         full
);
  localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int HALF   = FIFO_DEPTH / 2;
  localparam int LCNT_W = LBL_IDX_W + 1;

  logic [CNT_W-1:0]  fillCount;
  logic [LCNT_W-1:0] labWrCnt;
  logic [LCNT_W-1:0] labRdCnt;
  logic              wordPass;
  logic              acceptWord;
  logic              popReq;
  logic              isFull;

  always_comb begin
    wordPass   = (!labelMatchEn || labelHit) && (!sdiCheckEn || sdiHit);
    acceptWord = wordValid && !labelMode && wordPass;
    popReq     = hostRead && !labelMode && (fillCount != '0);
    isFull     = fillCount == CNT_W'(FIFO_DEPTH);

    strb            = '0;
    strb.push       = acceptWord && !(isFull && !popReq);
    strb.overwrite  = acceptWord && isFull && !popReq;
    strb.pop        = popReq;
    strb.labWe      = labelMode && hostWrite && (labWrCnt < LCNT_W'(LBL_COUNT));
    strb.labWrIdx   = labWrCnt[LBL_IDX_W-1:0];
    strb.labRdIdx   = labRdCnt[LBL_IDX_W-1:0];
    strb.labRdValid = labRdCnt < LCNT_W'(LBL_COUNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillCount <= '0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   fillCount <= fillCount + CNT_W'(1);
        2'b01:   fillCount <= fillCount - CNT_W'(1);
        default: fillCount <= fillCount;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      labWrCnt <= '0;
      labRdCnt <= '0;
    end else if (!labelMode) begin
      labWrCnt <= '0;
      labRdCnt <= '0;
    end else begin
      if (strb.labWe) labWrCnt <= labWrCnt + LCNT_W'(1);
      if (hostRead && strb.labRdValid) labRdCnt <= labRdCnt + LCNT_W'(1);
    end
  end

  assign dataReady = fillCount != '0;
  assign halfFull  = fillCount >= CNT_W'(HALF);
  assign full      = isFull;

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(FIFO_DEPTH));

  assert_suspend_R9: assert property (@(posedge clk) disable iff (!rstN)
    labelMode |=> $stable(fillCount));

  assert_full_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (full && wordValid && !hostRead && !labelMode) |=> full);

  assert_ready_fall_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataReady) |-> $past(hostRead));

  assert_lbl_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    labelMode |=> (labWrCnt == $past(labWrCnt)) || (labWrCnt == $past(labWrCnt) + LCNT_W'(1)));
endmodule

// File: rtl/rx_label_filter_dp.sv
module rx_label_filter_dp
  import rx_label_filter_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  filt_strobe_t       strb,
  input  logic [WORD_W-1:0]  wordIn,
  input  logic [LABEL_W-1:0] hostLabelIn,
  input  logic [1:0]         sdiExpect,
  output logic               labelHit,
  output logic               sdiHit,
  output logic [WORD_W-1:0]  rdData,
  output logic [LABEL_W-1:0] labelOut
);
  localparam int PTR_W = $clog2(FIFO_DEPTH);

  logic [LABEL_W-1:0]   labelMem [LBL_COUNT];
  logic [LBL_COUNT-1:0] hitVec;
  logic [WORD_W-1:0]    fifoMem [FIFO_DEPTH];
  logic [PTR_W-1:0]     wrPtr;
  logic [PTR_W-1:0]     rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LBL_COUNT; i++) labelMem[i] <= '0;
    end else if (strb.labWe) begin
      labelMem[strb.labWrIdx] <= hostLabelIn;
    end
  end

  for (genvar g = 0; g < LBL_COUNT; g++) begin : g_cmp
    assign hitVec[g] = labelMem[g] == wordIn[LABEL_W-1:0];
  end

  assign labelHit = |hitVec;
  assign sdiHit   = wordIn[LABEL_W+1:LABEL_W] == sdiExpect;
  assign labelOut = strb.labRdValid ? labelMem[strb.labRdIdx] : '0;

  always_ff @(posedge clk) begin
    if (strb.push)      fifoMem[wrPtr] <= wordIn;
    if (strb.overwrite) fifoMem[wrPtr - PTR_W'(1)] <= wordIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + PTR_W'(1);
      if (strb.pop)  rdPtr <= rdPtr + PTR_W'(1);
    end
  end

  assign rdData = fifoMem[rdPtr];

  assert_overwrite_keeps_ptrs_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strb.overwrite && !strb.pop) |=> $stable(wrPtr) && $stable(rdPtr));

  assert_lbl_store_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.labWe |=> labelMem[$past(strb.labWrIdx)] == $past(hostLabelIn));
endmodule

// File: rtl/rx_label_filter.sv
module rx_label_filter
  import rx_label_filter_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  wordIn,
  input  logic               wordValid,
  input  logic               labelMatchEn,
  input  logic               sdiCheckEn,
  input  logic [1:0]         sdiExpect,
  input  logic               labelMode,
  input  logic               hostWrite,
  input  logic               hostRead,
  input  logic [LABEL_W-1:0] hostLabelIn,
  output logic [WORD_W-1:0]  rdData,
  output logic [LABEL_W-1:0] labelOut,
  output logic               dataReady,
  output logic               halfFull,
  output logic               full
);
  filt_strobe_t strb;
  logic         labelHit;
  logic         sdiHit;

  rx_label_filter_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid),
    .labelMatchEn(labelMatchEn), .sdiCheckEn(sdiCheckEn),
    .labelHit(labelHit), .sdiHit(sdiHit), .labelMode(labelMode),
    .hostWrite(hostWrite), .hostRead(hostRead), .strb(strb),
    .dataReady(dataReady), .halfFull(halfFull), .full(full)
  );

  rx_label_filter_dp #(.WORD_W(WORD_W), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wordIn(wordIn),
    .hostLabelIn(hostLabelIn), .sdiExpect(sdiExpect),
    .labelHit(labelHit), .sdiHit(sdiHit), .rdData(rdData), .labelOut(labelOut)
  );
endmodule

// File: tb/rx_label_filter_test.sv
module rx_label_filter_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] wordIn = '0;
  logic        wordValid = 0;
  logic        labelMatchEn = 0;
  logic        sdiCheckEn = 0;
  logic [1:0]  sdiExpect = '0;
  logic        labelMode = 0;
  logic        hostWrite = 0;
  logic        hostRead = 0;
  logic [7:0]  hostLabelIn = '0;
  logic [31:0] rdData;
  logic [7:0]  labelOut;
  logic        dataReady, halfFull, full;

  int checks = 0;
  int errors = 0;
  logic [31:0] expQ[$];
  logic [7:0]  tbl[16];

  always #10 clk = ~clk;

  rx_label_filter uut (
    .clk(clk), .rstN(rstN), .wordIn(wordIn), .wordValid(wordValid),
    .labelMatchEn(labelMatchEn), .sdiCheckEn(sdiCheckEn), .sdiExpect(sdiExpect),
    .labelMode(labelMode), .hostWrite(hostWrite), .hostRead(hostRead),
    .hostLabelIn(hostLabelIn), .rdData(rdData), .labelOut(labelOut),
    .dataReady(dataReady), .halfFull(halfFull), .full(full)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [7:0] lbl, input logic [1:0] sdi,
                                     input logic [21:0] upper);
    return {upper, sdi, lbl};
  endfunction

  // driver: send a word, predict its fate into the scoreboard
  task automatic sendWord(input logic [31:0] w, input bit expectLoad, input string req);
    @(negedge clk);
    wordIn = w; wordValid = 1;
    @(negedge clk);
    wordValid = 0;
    if (expectLoad) begin
      if (expQ.size() == 32) expQ[31] = w;
      else expQ.push_back(w);
    end
    chk(dataReady == (expQ.size() != 0), req, "dataReady after word",
        32'(dataReady), 32'(expQ.size() != 0));
  endtask

  // monitor: compare oldest word and pop it
  task automatic popCheck(input string req);
    logic [31:0] e;
    @(negedge clk);
    e = expQ.pop_front();
    chk(rdData == e, req, "rdData", rdData, e);
    hostRead = 1;
    @(negedge clk);
    hostRead = 0;
  endtask

  task automatic drain(input string req);
    while (expQ.size() > 0) popCheck(req);
    @(negedge clk);
    chk(dataReady == 0, "R10", "dataReady after drain", 32'(dataReady), 0);
  endtask

  task automatic writeLabel(input logic [7:0] v);
    @(negedge clk);
    hostLabelIn = v; hostWrite = 1;
    @(negedge clk);
    hostWrite = 0;
  endtask

  task automatic readLabel(input logic [7:0] e, input string req);
    @(negedge clk);
    chk(labelOut == e, req, "labelOut", 32'(labelOut), 32'(e));
    hostRead = 1;
    @(negedge clk);
    hostRead = 0;
  endtask

  task automatic setMode(input logic m);
    @(negedge clk);
    labelMode = m;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(dataReady == 0, "R1", "dataReady", 32'(dataReady), 0);
    chk(halfFull == 0, "R1", "halfFull", 32'(halfFull), 0);
    chk(full == 0, "R1", "full", 32'(full), 0);
    setMode(1);
    readLabel(8'h00, "R1");
    setMode(0);

    // R5 both checks off: everything queued, R10 order
    sendWord(mk(8'hA1, 2'b11, 22'h1), 1, "R5");
    sendWord(mk(8'h00, 2'b00, 22'h2), 1, "R5");
    sendWord(mk(8'h5C, 2'b01, 22'h3), 1, "R5");
    drain("R10");

    // R6 table load, R9 suspension, R7 readback
    for (int i = 0; i < 16; i++) tbl[i] = 8'(8'h10 + i * 3);
    setMode(1);
    for (int i = 0; i < 16; i++) writeLabel(tbl[i]);
    writeLabel(8'hFF);                       // R6 17th write ignored
    sendWord(mk(8'h22, 2'b00, 22'h9), 0, "R9");
    for (int i = 0; i < 16; i++) readLabel(tbl[i], "R6");
    readLabel(8'h00, "R7");                  // past the 16th
    setMode(0);
    @(negedge clk);
    chk(dataReady == 0, "R7", "queue untouched by label reads", 32'(dataReady), 0);

    // R2 label matching
    labelMatchEn = 1;
    sendWord(mk(8'h77, 2'b00, 22'h4), 0, "R2");
    sendWord(mk(8'h00, 2'b00, 22'h5), 0, "R3");
    sendWord(mk(tbl[5], 2'b10, 22'h6), 1, "R2");
    sendWord(mk(8'h3E, 2'b00, 22'h7), 0, "R2");
    sendWord(mk(tbl[15], 2'b01, 22'h8), 1, "R2");
    drain("R2");

    // R8 session restart at location 1, R3 zero label
    setMode(1);
    writeLabel(8'h00);
    readLabel(8'h00, "R8");
    readLabel(tbl[1], "R8");
    setMode(0);
    sendWord(mk(8'h00, 2'b00, 22'hA), 1, "R3");
    sendWord(mk(tbl[0], 2'b00, 22'hB), 0, "R8");
    drain("R3");

    // R4 source/destination check
    labelMatchEn = 0; sdiCheckEn = 1; sdiExpect = 2'b10;
    sendWord(mk(8'h99, 2'b10, 22'hC), 1, "R4");
    sendWord(mk(8'h99, 2'b01, 22'hD), 0, "R4");
    sendWord(mk(8'h99, 2'b11, 22'hE), 0, "R4");
    sendWord(mk(8'h99, 2'b00, 22'hF), 0, "R4");
    // R5 both enabled
    labelMatchEn = 1;
    sendWord(mk(tbl[3], 2'b01, 22'h10), 0, "R5");
    sendWord(mk(8'h99, 2'b10, 22'h11), 0, "R5");
    sendWord(mk(tbl[3], 2'b10, 22'h12), 1, "R5");
    drain("R4");

    // R11 / R12 fill and overwrite
    labelMatchEn = 0; sdiCheckEn = 0;
    for (int i = 0; i < 15; i++) sendWord(32'hC000_0000 + i, 1, "R11");
    chk(halfFull == 0, "R11", "halfFull at 15", 32'(halfFull), 0);
    sendWord(32'hC000_000F, 1, "R11");
    chk(halfFull == 1, "R11", "halfFull at 16", 32'(halfFull), 1);
    for (int i = 16; i < 31; i++) sendWord(32'hC000_0000 + i, 1, "R11");
    chk(full == 0, "R11", "full at 31", 32'(full), 0);
    sendWord(32'hC000_001F, 1, "R11");
    chk(full == 1, "R11", "full at 32", 32'(full), 1);
    sendWord(32'hDEAD_BEEF, 1, "R12");
    chk(full == 1, "R12", "full after overwrite", 32'(full), 1);
    chk(expQ[31] == 32'hDEAD_BEEF && expQ[30] == 32'hC000_001E, "R12",
        "scoreboard model", expQ[31], 32'hDEAD_BEEF);
    popCheck("R12");
    @(negedge clk);
    chk(full == 0, "R11", "full after one pop", 32'(full), 0);
    chk(halfFull == 1, "R11", "halfFull at 31", 32'(halfFull), 1);
    drain("R12");
    chk(halfFull == 0, "R11", "halfFull empty", 32'(halfFull), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule